// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker resolves a 32-bit effective address to a real address by searching an in-memory hashed page table. It is started after a block-level translation has missed. The top four address bits pick one of sixteen segment words, which supply a virtual segment identifier and two protection keys. From these and the page index, the walker computes a 64-byte group address and an expected tag. It then fetches the group's sixteen big-endian words, one per handshake beat, and compares them as eight (tag, payload) pairs.

If the primary group holds no matching pair, the whole search repeats with the complemented hash and the secondary tag flag set. On a match, the walker decodes the access rights from the entry's two protection bits and the segment key. It then sets the entry's referenced and changed flags, when needed, with single-byte stores into the payload word.

A one-cycle completion pulse reports one of three results: hit, protection fault or not found. The real address and the read, write and execute rights come with it and stay on the outputs until the next walk completes.

Top module: `pt_walker`

## Requirements
- R1: The segment word is chosen by EA[31:28]; VSID is its low 28 bits. The first read of a walk goes to the primary group address: (base & 0xFFFF0000) | (((VSID ^ EA[27:12]) << 6) & (((base & 0x1FF) << 16) | 0xFFC0)).
- R2: Reads are word-aligned. They step through the group in ascending word order, one word per cycle in which rd_valid_o and rd_ready_i are both high. While rd_ready_i is low, rd_valid_o and rd_addr_o hold.
- R3: The expected tag is 0x80000000 | (VSID << 7) | (0x40 on the secondary search) | EA[27:22]. The match is the lowest-numbered pair whose even word equals the tag. For it, raddr_o = {odd word[31:12], EA[11:0]}. A permitted access reports res_o = 0 (hit).
- R4: The rights code is {key, odd word[1:0]}, where key is segment bit 29 in user mode and segment bit 30 in supervisor mode. Codes 0, 1, 2 and 6 grant read and write. Codes 3, 5 and 7 grant read only. Code 4 grants nothing. may_ex_o is 1 whenever an entry matched and 0 on not found.
- R5: If the matched entry is readable and its odd word bit 8 is clear, the walker stores byte (odd[15:8] | 0x01) at the odd word's address + 2.
- R6: If the access is a write, the entry is writable and odd word bit 7 is clear, the walker stores byte (odd[7:0] | 0x80) at the odd word's address + 3. This store comes after any store from R5. Each store completes in a cycle in which wr_valid_o and wr_ready_i are both high.
- R7: A matched entry that denies the access (no read, or a write without write rights) reports res_o = 1 (protection fault). The flag stores still take place, and no further reads are made.
- R8: A primary search with no match is followed by the secondary search, which uses the bitwise complement of the hash. If neither search matches, the walk makes exactly 32 reads and ends with res_o = 2 (not found), raddr_o = 0 and all rights 0.
- R9: done_o is high for exactly one cycle per walk. res_o, raddr_o and the rights change only in the cycle in which done_o is high.
- R10: After reset, done_o, rd_valid_o and wr_valid_o are 0, res_o is 2, and raddr_o and the rights are 0.
- R11: rd_valid_o and wr_valid_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (sampled while idle) |
| req_ea_i | input | 32 | Effective address to translate |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_write_i | input | 1 | 1 = store access |
| base_i | input | 32 | Table base and size-mask register |
| seg_i | input | 512 | Sixteen segment words, word n at bits [32n+31:32n] |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read byte address (word-aligned) |
| rd_ready_i | input | 1 | Read accepted; rd_data_i valid this cycle |
| rd_data_i | input | 32 | Read word, byte 0 in bits [31:24] |
| wr_valid_o | output | 1 | Byte store valid |
| wr_addr_o | output | 32 | Byte store address |
| wr_byte_o | output | 8 | Byte store data |
| wr_ready_i | input | 1 | Byte store accepted |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 2 | 0 hit, 1 protection fault, 2 not found |
| raddr_o | output | 32 | Translated real address |
| may_rd_o | output | 1 | Read permitted |
| may_wr_o | output | 1 | Write permitted |
| may_ex_o | output | 1 | Execute permitted |

## Verification
The bench goes after the matches that sit at the edges of the pair scan: the last pair of a group, where a wrong index wrap would write back to pair 0's address, and two matching pairs, where a scan that keeps the last hit returns the wrong real address. It plants a primary-group decoy that carries the secondary tag, so a design that forgets the tag flag or the complemented hash hits early or reads the wrong group. It uses a base register whose mask bits are set, which the complemented hash only reaches through the mask. It covers key-modified code 4 and read-only code 3 on a write, where a design that drops the key, or searches on after a denial, reports the wrong result or issues extra reads. It also covers the referenced and changed stores in their order, including an entry whose flags are already set, where a careless design writes again. Throughout, both ready signals are stalled so that a walker that lets its address drift under backpressure fetches the wrong word.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] VSID_MASK = 32'h0FFF_FFFF;
  localparam logic [WORD_W-1:0] SKEY_MASK = 32'h4000_0000;
  localparam logic [WORD_W-1:0] UKEY_MASK = 32'h2000_0000;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_COMPARE, ST_UPDATE, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    RES_HIT  = 2'd0,
    RES_PROT = 2'd1,
    RES_MISS = 2'd2
  } walk_res_e;
endpackage

// File: rtl/pt_hash.sv
module pt_hash
  import pt_walker_pkg::*;
(
  input  logic [WORD_W-1:0] vsid_i,
  input  logic [15:0]       page_i,
  input  logic [5:0]        api_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic              sec_i,
  output logic [WORD_W-1:0] group_o,
  output logic [WORD_W-1:0] tag_o
);
  logic [WORD_W-1:0] hash_raw, hash_sel, mask;

  always_comb begin
    hash_raw = (vsid_i ^ {16'h0, page_i}) << 6;
    hash_sel = sec_i ? ~hash_raw : hash_raw;
    mask     = ((base_i & 32'h0000_01FF) << 16) | 32'h0000_FFC0;
    group_o  = (base_i & 32'hFFFF_0000) | (hash_sel & mask);
    tag_o    = 32'h8000_0000 | (vsid_i << 7) | (sec_i ? 32'h40 : 32'h0) | {26'h0, api_i};
  end
endmodule

// File: rtl/pt_prot.sv
module pt_prot (
  input  logic [1:0] pp_i,
  input  logic       key_i,
  input  logic       write_i,
  output logic       rd_o,
  output logic       wr_o,
  output logic       deny_o
);
  logic [2:0] code;

  always_comb begin
    code = {key_i, pp_i};
    unique case (code)
      3'd0, 3'd1, 3'd2, 3'd6: begin rd_o = 1'b1; wr_o = 1'b1; end
      3'd3, 3'd5, 3'd7:       begin rd_o = 1'b1; wr_o = 1'b0; end
      default:                begin rd_o = 1'b0; wr_o = 1'b0; end
    endcase
    deny_o = !rd_o || (write_i && !wr_o);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int NUM_SEG   = 16,
  parameter int NUM_PAIRS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [WORD_W-1:0]          req_ea_i,
  input  logic                       req_user_i,
  input  logic                       req_write_i,
  input  logic [WORD_W-1:0]          base_i,
  input  logic [NUM_SEG*WORD_W-1:0]  seg_i,
  output logic                       rd_valid_o,
  output logic [WORD_W-1:0]          rd_addr_o,
  input  logic                       rd_ready_i,
  input  logic [WORD_W-1:0]          rd_data_i,
  output logic                       wr_valid_o,
  output logic [WORD_W-1:0]          wr_addr_o,
  output logic [7:0]                 wr_byte_o,
  input  logic                       wr_ready_i,
  output logic                       done_o,
  output logic [1:0]                 res_o,
  output logic [WORD_W-1:0]          raddr_o,
  output logic                       may_rd_o,
  output logic                       may_wr_o,
  output logic                       may_ex_o
);
  localparam int SEG_W = $clog2(NUM_SEG);
  localparam int IDX_W = $clog2(2 * NUM_PAIRS);
  localparam int EA_LO = WORD_W - SEG_W;

  walk_state_e       state_q;
  logic [EA_LO-1:0]  ea_q;
  logic [WORD_W-1:0] vsid_q;
  logic              key_q, write_q, sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic              need_ref_q, need_chg_q;
  walk_res_e         res_q;
  logic [WORD_W-1:0] raddr_q;
  logic              mrd_q, mwr_q, mex_q;

  // segment word pick and key selection at request time
  logic [SEG_W-1:0]  seg_sel;
  logic [WORD_W-1:0] seg_word;
  logic              seg_key;
  assign seg_sel  = req_ea_i[WORD_W-1 -: SEG_W];
  assign seg_word = seg_i[seg_sel*WORD_W +: WORD_W];
  assign seg_key  = req_user_i ? |(seg_word & UKEY_MASK) : |(seg_word & SKEY_MASK);

  logic [WORD_W-1:0] group_w, tag_w;
  pt_hash u_hash (
    .vsid_i (vsid_q),
    .page_i (ea_q[27:12]),
    .api_i  (ea_q[27:22]),
    .base_i (base_i),
    .sec_i  (sec_q),
    .group_o(group_w),
    .tag_o  (tag_w)
  );

  logic prot_rd, prot_wr, prot_deny;
  pt_prot u_prot (
    .pp_i   (w1_q[1:0]),
    .key_i  (key_q),
    .write_i(write_q),
    .rd_o   (prot_rd),
    .wr_o   (prot_wr),
    .deny_o (prot_deny)
  );

  logic [IDX_W-1:0]  odd_idx;
  logic [WORD_W-1:0] odd_addr;
  assign odd_idx  = idx_q - IDX_W'(1);
  assign odd_addr = group_w + WORD_W'({odd_idx, 2'b00});

  assign rd_valid_o = (state_q == ST_FETCH);
  assign rd_addr_o  = group_w + WORD_W'({idx_q, 2'b00});
  assign wr_valid_o = (state_q == ST_UPDATE) && (need_ref_q || need_chg_q);
  assign wr_addr_o  = odd_addr + (need_ref_q ? 32'd2 : 32'd3);
  assign wr_byte_o  = need_ref_q ? (w1_q[15:8] | 8'h01) : (w1_q[7:0] | 8'h80);
  assign done_o     = (state_q == ST_DONE);
  assign res_o      = res_q;
  assign raddr_o    = raddr_q;
  assign may_rd_o   = mrd_q;
  assign may_wr_o   = mwr_q;
  assign may_ex_o   = mex_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ea_q       <= '0;
      vsid_q     <= '0;
      key_q      <= 1'b0;
      write_q    <= 1'b0;
      sec_q      <= 1'b0;
      idx_q      <= '0;
      w0_q       <= '0;
      w1_q       <= '0;
      need_ref_q <= 1'b0;
      need_chg_q <= 1'b0;
      res_q      <= RES_MISS;
      raddr_q    <= '0;
      mrd_q      <= 1'b0;
      mwr_q      <= 1'b0;
      mex_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          ea_q    <= req_ea_i[EA_LO-1:0];
          vsid_q  <= seg_word & VSID_MASK;
          key_q   <= seg_key;
          write_q <= req_write_i;
          sec_q   <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (rd_ready_i) begin
          idx_q <= idx_q + IDX_W'(1);
          if (!idx_q[0]) w0_q <= rd_data_i;
          else begin
            w1_q    <= rd_data_i;
            state_q <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          if (w0_q == tag_w) begin
            need_ref_q <= prot_rd && !w1_q[REF_BIT];
            need_chg_q <= write_q && prot_wr && !w1_q[CHG_BIT];
            state_q    <= ST_UPDATE;
          end else if (idx_q != '0) begin
            state_q <= ST_FETCH;
          end else if (!sec_q) begin
            sec_q   <= 1'b1;       // idx_q already wrapped to pair 0
            state_q <= ST_FETCH;
          end else begin
            res_q   <= RES_MISS;
            raddr_q <= '0;
            mrd_q   <= 1'b0;
            mwr_q   <= 1'b0;
            mex_q   <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_UPDATE: begin
          if (!need_ref_q && !need_chg_q) begin
            res_q   <= prot_deny ? RES_PROT : RES_HIT;
            raddr_q <= {w1_q[WORD_W-1:12], ea_q[11:0]};
            mrd_q   <= prot_rd;
            mwr_q   <= prot_wr;
            mex_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (wr_ready_i) begin
            if (need_ref_q) need_ref_q <= 1'b0;
            else            need_chg_q <= 1'b0;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  no_rdwr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_o) && $stable(raddr_o) && $stable(may_rd_o) && $stable(may_wr_o)));
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
  // R2
  rd_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_addr_o[1:0] == 2'b00));
  // R4
  perm_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    may_wr_o |-> may_rd_o);
  // R7
  fault_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && res_o == RES_PROT) |-> (!may_rd_o || (write_q && !may_wr_o)));
  // R3
  hit_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && res_o == RES_HIT) |-> (may_rd_o && (!write_q || may_wr_o)));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [31:0]  req_ea_i = '0;
  logic         req_user_i = 1'b0;
  logic         req_write_i = 1'b0;
  logic [31:0]  base_i = 32'h0002_0000;
  logic [511:0] seg_i = '0;
  logic         rd_valid_o, wr_valid_o, done_o, may_rd_o, may_wr_o, may_ex_o;
  logic [31:0]  rd_addr_o, wr_addr_o, raddr_o;
  logic         rd_ready_i = 1'b0, wr_ready_i = 1'b0;
  logic [31:0]  rd_data_i = '0;
  logic [7:0]   wr_byte_o;
  logic [1:0]   res_o;

  pt_walker uut (
    .clk_i, .rst_ni, .req_valid_i, .req_ea_i, .req_user_i, .req_write_i,
    .base_i, .seg_i, .rd_valid_o, .rd_addr_o, .rd_ready_i, .rd_data_i,
    .wr_valid_o, .wr_addr_o, .wr_byte_o, .wr_ready_i, .done_o, .res_o,
    .raddr_o, .may_rd_o, .may_wr_o, .may_ex_o
  );

  initial forever #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stall_en = 0, first_rd = 0;
  logic [31:0] mem [bit [31:0]];
  logic [31:0] exp_rd [$];
  logic [39:0] exp_wr [$];
  logic [1:0]  exp_res;
  logic [31:0] exp_raddr;
  logic        exp_mr, exp_mw, exp_mx;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] f_group(input logic [31:0] vsid, input logic [15:0] page,
                                          input logic [31:0] base, input bit sec);
    logic [31:0] h, m;
    h = (vsid ^ {16'h0, page}) << 6;
    if (sec) h = ~h;
    m = ((base & 32'h1FF) << 16) | 32'hFFC0;
    return (base & 32'hFFFF0000) | (h & m);
  endfunction

  function automatic logic [31:0] f_tag(input logic [31:0] vsid, input logic [5:0] api, input bit sec);
    return 32'h80000000 | (vsid << 7) | (sec ? 32'h40 : 32'h0) | {26'h0, api};
  endfunction

  function automatic logic [31:0] seg_of(input logic [31:0] ea);
    return seg_i[ea[31:28]*32 +: 32];
  endfunction

  // place an entry whose even word carries the tag for (ea, tag_sec) in group (ea, grp_sec)
  task automatic place(input logic [31:0] ea, input bit grp_sec, input bit tag_sec,
                       input int pair, input logic [31:0] w1);
    logic [31:0] v, g;
    v = seg_of(ea) & 32'h0FFFFFFF;
    g = f_group(v, ea[27:12], base_i, grp_sec);
    mem[g + 8*pair]     = f_tag(v, ea[27:22], tag_sec);
    mem[g + 8*pair + 4] = w1;
  endtask

  task automatic model(input logic [31:0] ea, input bit user, input bit wr);
    logic [31:0] sr, v, g, w1, odd;
    bit found, key, mr, mw;
    logic [2:0] code;
    sr = seg_of(ea);
    v = sr & 32'h0FFFFFFF;
    key = user ? sr[29] : sr[30];
    exp_rd.delete(); exp_wr.delete();
    found = 0; w1 = '0; odd = '0;
    for (int s = 0; s < 2 && !found; s++) begin
      g = f_group(v, ea[27:12], base_i, s[0]);
      for (int p = 0; p < 8 && !found; p++) begin
        exp_rd.push_back(g + 8*p);
        exp_rd.push_back(g + 8*p + 4);
        if (rdw(g + 8*p) == f_tag(v, ea[27:22], s[0])) begin
          found = 1; odd = g + 8*p + 4; w1 = rdw(odd);
        end
      end
    end
    if (found) begin
      code = {key, w1[1:0]};
      mr = (code != 3'd4);
      mw = (code == 3'd0 || code == 3'd1 || code == 3'd2 || code == 3'd6);
      if (mr && !w1[8]) exp_wr.push_back({odd + 32'd2, w1[15:8] | 8'h01});
      if (wr && mw && !w1[7]) exp_wr.push_back({odd + 32'd3, w1[7:0] | 8'h80});
      exp_res = (!mr || (wr && !mw)) ? 2'd1 : 2'd0;
      exp_raddr = {w1[31:12], ea[11:0]};
      exp_mr = mr; exp_mw = mw; exp_mx = 1'b1;
    end else begin
      exp_res = 2'd2; exp_raddr = '0; exp_mr = 0; exp_mw = 0; exp_mx = 0;
    end
  endtask

  // memory responder and per-cycle monitors
  logic [1:0]  prev_res;
  logic [31:0] prev_raddr;
  logic        prev_mr, prev_mw, prev_ok = 0;
  initial forever begin
    @(negedge clk_i);
    cyc++;
    rd_ready_i = stall_en ? (cyc % 3 != 0) : 1'b1;
    wr_ready_i = stall_en ? (cyc % 2 == 0) : 1'b1;
    rd_data_i  = rd_valid_o ? rdw(rd_addr_o) : 32'h0;
    if (rst_ni) begin
      check(!(rd_valid_o && wr_valid_o), "R11", "read and write together", {rd_valid_o, wr_valid_o}, 0);
      // R9 results hold outside the done cycle
      if (prev_ok && !done_o)
        check(res_o == prev_res && raddr_o == prev_raddr && may_rd_o == prev_mr && may_wr_o == prev_mw,
              "R9", "result changed without done", {res_o, raddr_o}, {prev_res, prev_raddr});
      prev_res = res_o; prev_raddr = raddr_o; prev_mr = may_rd_o; prev_mw = may_wr_o; prev_ok = 1;
      if (rd_valid_o && rd_ready_i) begin
        if (exp_rd.size() == 0) check(0, "R2", "unexpected read", rd_addr_o, 0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          check(rd_addr_o == e, first_rd ? "R1" : "R2", "read address", rd_addr_o, e);
          first_rd = 0;
        end
      end
      if (wr_valid_o && wr_ready_i) begin
        if (exp_wr.size() == 0) check(0, "R7", "unexpected byte store", {wr_addr_o, wr_byte_o}, 0);
        else begin
          logic [39:0] e;
          e = exp_wr.pop_front();
          check({wr_addr_o, wr_byte_o} == e, (e[9:8] == 2'd2) ? "R5" : "R6", "byte store",
                {wr_addr_o, wr_byte_o}, e);
        end
        begin
          logic [31:0] wa, wv;
          wa = {wr_addr_o[31:2], 2'b00};
          wv = rdw(wa);
          wv[(3 - wr_addr_o[1:0])*8 +: 8] = wr_byte_o;  // big-endian byte lanes
          mem[wa] = wv;
        end
      end
    end
  end

  task automatic run_walk(input logic [31:0] ea, input bit user, input bit wr, input string req);
    int n;
    model(ea, user, wr);
    first_rd = 1;
    @(negedge clk_i);
    req_valid_i = 1; req_ea_i = ea; req_user_i = user; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 0;
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk_i); n++; end
    check(done_o, "R9", "done seen", done_o, 1);
    check(res_o == exp_res, req, "result code", res_o, exp_res);
    check(raddr_o == exp_raddr, "R3", "real address", raddr_o, exp_raddr);
    check({may_rd_o, may_wr_o, may_ex_o} == {exp_mr, exp_mw, exp_mx}, "R4", "rights",
          {may_rd_o, may_wr_o, may_ex_o}, {exp_mr, exp_mw, exp_mx});
    @(negedge clk_i);
    check(!done_o, "R9", "done one cycle", done_o, 0);
    check(exp_rd.size() == 0, "R8", "reads left over", exp_rd.size(), 0);
    check(exp_wr.size() == 0, "R6", "stores left over", exp_wr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [31:0] EA_A = 32'h3ABC_D123;
  localparam logic [31:0] EA_B = 32'hC123_4567;

  initial begin
    seg_i[3*32 +: 32]  = 32'h2012_3456;   // user key set, supervisor key clear
    seg_i[12*32 +: 32] = 32'h4FFF_FFFF;   // supervisor key set
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(!done_o && !rd_valid_o && !wr_valid_o, "R10", "reset strobes",
          {done_o, rd_valid_o, wr_valid_o}, 0);
    check(res_o == 2'd2 && raddr_o == 0 && !may_rd_o && !may_wr_o && !may_ex_o, "R10",
          "reset result", {res_o, raddr_o}, {2'd2, 32'h0});
    rst_ni = 1;
    @(negedge clk_i);

    // R3 R5 supervisor read, pair 0, code 2
    place(EA_A, 0, 0, 0, 32'h1234_5002);
    run_walk(EA_A, 0, 0, "R3");
    // R6 same entry, referenced now set: only changed store
    run_walk(EA_A, 0, 1, "R3");
    // R6 user write, code 6, last pair, both stores, with stalls
    mem.delete(); stall_en = 1;
    place(EA_A, 0, 0, 7, 32'hABCD_E002);
    run_walk(EA_A, 1, 1, "R6");
    // R4 R7 code 4: nothing allowed, no stores, no secondary
    mem.delete();
    place(EA_A, 0, 0, 3, 32'h5555_5000);
    place(EA_A, 1, 1, 0, 32'h6666_6002);
    run_walk(EA_A, 1, 0, "R7");
    // R7 write on read-only code 3: fault with referenced store only
    mem.delete(); stall_en = 0;
    place(EA_A, 0, 0, 2, 32'h7777_7003);
    run_walk(EA_A, 0, 1, "R7");
    // R4 user read on code 5
    mem.delete();
    place(EA_A, 0, 0, 4, 32'h8888_8181);
    run_walk(EA_A, 1, 0, "R4");
    // R8 secondary hit behind a decoy carrying the secondary tag in the primary group
    mem.delete(); stall_en = 1;
    place(EA_A, 0, 1, 2, 32'h9999_9002);
    place(EA_A, 1, 1, 4, 32'h4242_4182);
    run_walk(EA_A, 0, 1, "R8");
    // R8 not found in either group
    mem.delete();
    run_walk(EA_A, 0, 0, "R8");
    // R3 first of two matching pairs wins
    mem.delete(); stall_en = 0;
    place(EA_A, 0, 0, 3, 32'hBBBB_B002);
    place(EA_A, 0, 0, 1, 32'hAAAA_A102);
    run_walk(EA_A, 0, 0, "R3");
    // R1 R8 mask bits in base, complemented hash, supervisor key code 6
    mem.delete(); stall_en = 1;
    base_i = 32'h0100_01FF;
    place(EA_B, 1, 1, 1, 32'hCAFE_F002);
    run_walk(EA_B, 0, 1, "R1");
    // R8 same base, primary miss path fully exhausted
    mem.delete();
    run_walk(EA_B, 1, 1, "R8");

    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule